// File: doc/BRIEF.md
# Periodic Peripheral Autopoll Scheduler

This block keeps a millisecond countdown and, while autopolling is switched on, asks a peripheral bus front end to poll the devices chosen by a 16-bit selection mask once per period. The front end answers each poll with a result that carries zero or more data bytes. A result that carries bytes is framed as an unsolicited packet and sent to the host on a byte stream with valid/ready flow control. A result with no bytes produces no packet.

A command decoder configures the block through a single write port. Each write names a setting (enable, period, device mask), gives how many argument bytes came with it, and supplies those bytes. The block accepts or rejects the write and reports that one cycle later. A free-running millisecond strobe paces the countdown.

There are two state machines. The scheduler has the states OFF, ARMED and FIRE. OFF goes to ARMED on an accepted enable, loading the period. ARMED or FIRE goes to OFF on a disable. ARMED or FIRE goes to ARMED with a fresh count on a restart. ARMED goes to FIRE on an expiry when no poll is blocked. FIRE always returns to ARMED after one cycle. The framer has the states IDLE, TYPE, TAG and BODY. IDLE goes to TYPE when a result is loaded directly or taken from the hold slot. TYPE goes to TAG, and TAG goes to BODY, each on an accepted byte. BODY goes back to IDLE when the last byte is accepted.

Top module: `autopoll_sched`

## Requirements
- R1: After reset the period is 20 ms, the mask is 0xFFFF, autopolling is off, and `poll_req` and `pkt_valid` are low.
- R2: The enable write (`cfg_sel`=0) needs exactly one byte in `cfg_data[7:0]`. A nonzero byte switches autopolling on. When it was off, `poll_req` pulses after exactly one period of `ms_tick` strobes. When it was already on, the countdown is left untouched.
- R3: An enable write with a zero byte switches autopolling off and cancels the countdown. No `poll_req` is raised while it is off.
- R4: The period write (`cfg_sel`=1) needs exactly one byte in `cfg_data[7:0]`. A value of zero, or any other length, is rejected and leaves the period unchanged. An accepted period while autopolling is on restarts the countdown at the new value.
- R5: The mask write (`cfg_sel`=2) needs exactly two bytes. The first byte is `cfg_data[15:8]` and forms the high half of the mask. Any other length is rejected. The mask is shown on `poll_mask`.
- R6: A result with N bytes (1..MAX_BYTES) gives the packet 0x00, 0x40, then byte i from `poll_rsp_data[8i+7:8i]` in rising i. `pkt_last` marks the final byte. A stalled byte is held stable.
- R7: Every expiry reloads the countdown with the current period, whether or not data came back. A zero-length result emits nothing.
- R8: Reset switches autopolling off.
- R9: A result that arrives while a packet is still being sent is held. It is emitted after that packet, in arrival order.
- R10: An expiry that falls while a poll is still unanswered, or while the hold slot is full, raises no `poll_req` but still reloads the countdown.
- R11: A config write in the same cycle as an `ms_tick` wins: a disable prevents the poll, and a restart loads the new period and ignores that tick.
- R12: `cfg_ok` or `cfg_err` pulses for one cycle after each write. Selector 3 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Setting: 0 enable, 1 period, 2 mask, 3 unused |
| cfg_len | input | 2 | Number of argument bytes |
| cfg_data | input | 16 | Argument bytes; a one-byte argument is in [7:0] |
| cfg_ok | output | 1 | Write accepted (one cycle) |
| cfg_err | output | 1 | Write rejected (one cycle) |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| poll_req | output | 1 | One-cycle request to poll |
| poll_mask | output | MASK_W | Devices to poll |
| poll_rsp_valid | input | 1 | Poll result strobe |
| poll_rsp_len | input | LEN_W | Result byte count, 0 for none |
| poll_rsp_data | input | 8*MAX_BYTES | Result bytes, byte i at [8i+7:8i] |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of packet |
| pkt_ready | input | 1 | Host accepts byte |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a config write and the expiring millisecond strobe. The bench drives the write and the strobe together on the cycle where the countdown stands at one. It then judges by the poll count and by how many further strobes the next poll needs. The second pair is a poll result and a packet still draining. The bench holds the host side stalled across two polls. It then requires that the scoreboard receives both packets complete and in order once the host accepts again, and that the expiry that falls in between raises no poll.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
    typedef enum logic [1:0] {
        CFG_ENABLE  = 2'd0,
        CFG_RATE    = 2'd1,
        CFG_DEVMASK = 2'd2,
        CFG_UNUSED  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        SCH_OFF,
        SCH_ARMED,
        SCH_FIRE
    } sch_state_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_TYPE,
        FR_TAG,
        FR_BODY
    } fr_state_e;

    localparam logic [7:0] PKT_TYPE_BUS  = 8'h00;
    localparam logic [7:0] PKT_TAG_UNSOL = 8'h40;
endpackage

// File: rtl/ap_cfg.sv
module ap_cfg
    import autopoll_pkg::*;
#(
    parameter int RATE_W       = 8,
    parameter int MASK_W       = 16,
    parameter int DEFAULT_RATE = 20,
    parameter logic [MASK_W-1:0] DEFAULT_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [1:0]        cfg_len_i,
    input  logic [15:0]       cfg_data_i,
    output logic              cfg_ok_o,
    output logic              cfg_err_o,
    output logic              en_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [MASK_W-1:0] mask_o,
    output logic              load_o,
    output logic [RATE_W-1:0] load_val_o,
    output logic              stop_o
);
    logic              en_q, ok_q, err_q;
    logic [RATE_W-1:0] rate_q;
    logic [MASK_W-1:0] mask_q;
    logic              legal, accept, byte_nz, rate_wr, turn_on;
    cfg_sel_e          sel;

    assign sel     = cfg_sel_e'(cfg_sel_i);
    assign byte_nz = (cfg_data_i[7:0] != 8'h00);

    always_comb begin
        legal = 1'b0;
        unique case (sel)
            CFG_ENABLE:  legal = (cfg_len_i == 2'd1);
            CFG_RATE:    legal = (cfg_len_i == 2'd1) && byte_nz;
            CFG_DEVMASK: legal = (cfg_len_i == 2'd2);
            default:     legal = 1'b0;
        endcase
    end

    assign accept     = cfg_valid_i && legal;
    assign turn_on    = accept && (sel == CFG_ENABLE) && byte_nz && !en_q;
    assign stop_o     = accept && (sel == CFG_ENABLE) && !byte_nz;
    assign rate_wr    = accept && (sel == CFG_RATE);
    assign load_o     = turn_on || (rate_wr && en_q);
    assign load_val_o = rate_wr ? RATE_W'(cfg_data_i[7:0]) : rate_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rate_q <= RATE_W'(DEFAULT_RATE);
            mask_q <= DEFAULT_MASK;
            ok_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            ok_q  <= accept;
            err_q <= cfg_valid_i && !legal;
            if (accept && sel == CFG_ENABLE) en_q <= byte_nz;
            if (rate_wr) rate_q <= RATE_W'(cfg_data_i[7:0]);
            if (accept && sel == CFG_DEVMASK) mask_q <= cfg_data_i[MASK_W-1:0];
        end
    end

    assign cfg_ok_o  = ok_q;
    assign cfg_err_o = err_q;
    assign en_o      = en_q;
    assign rate_o    = rate_q;
    assign mask_o    = mask_q;

    assert_rate_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rate_q != '0);
    assert_result_follows_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_q || err_q) |-> $past(cfg_valid_i));
endmodule

// File: rtl/ap_timer.sv
module ap_timer
    import autopoll_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              load_i,
    input  logic [RATE_W-1:0] load_val_i,
    input  logic              stop_i,
    input  logic              tick_i,
    input  logic              rsp_seen_i,
    input  logic              hold_full_i,
    output logic              poll_req_o
);
    sch_state_e        st_q, st_d;
    logic [RATE_W-1:0] cnt_q, cnt_d;
    logic              outst_q, blocked;

    assign blocked = outst_q || hold_full_i || (st_q == SCH_FIRE);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            SCH_OFF: begin
                if (load_i) begin
                    st_d  = SCH_ARMED;
                    cnt_d = load_val_i;
                end
            end
            SCH_ARMED, SCH_FIRE: begin
                st_d = SCH_ARMED;
                if (stop_i) begin
                    st_d = SCH_OFF;
                end else if (load_i) begin
                    cnt_d = load_val_i;
                end else if (tick_i) begin
                    if (cnt_q == RATE_W'(1)) begin
                        cnt_d = rate_i;
                        if (!blocked) st_d = SCH_FIRE;
                    end else begin
                        cnt_d = cnt_q - RATE_W'(1);
                    end
                end
            end
            default: st_d = SCH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SCH_OFF;
            cnt_q   <= '0;
            outst_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == SCH_FIRE) outst_q <= 1'b1;
            else if (rsp_seen_i) outst_q <= 1'b0;
        end
    end

    always_comb begin
        poll_req_o = (st_q == SCH_FIRE);
    end

    assert_poll_only_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req_o |-> en_i);
    assert_poll_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req_o |=> !poll_req_o);
    assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SCH_OFF) |-> (cnt_q != '0));
endmodule

// File: rtl/ap_framer.sv
module ap_framer
    import autopoll_pkg::*;
#(
    parameter  int MAX_BYTES = 8,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1),
    localparam int DATA_W    = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid_i,
    input  logic [LEN_W-1:0]  rsp_len_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic              pkt_ready_i,
    output logic              pkt_valid_o,
    output logic [7:0]        pkt_data_o,
    output logic              pkt_last_o,
    output logic              hold_full_o
);
    fr_state_e         st_q, st_d;
    logic [DATA_W-1:0] tx_data_q, hold_data_q;
    logic [LEN_W-1:0]  tx_len_q, hold_len_q, idx_q;
    logic              hold_full_q;
    logic              has_data, take_hold, load_direct, last_byte;

    assign has_data    = rsp_valid_i && (rsp_len_i != '0);
    assign take_hold   = (st_q == FR_IDLE) && hold_full_q;
    assign load_direct = (st_q == FR_IDLE) && !hold_full_q && has_data;
    assign last_byte   = (st_q == FR_BODY) && (idx_q == tx_len_q - LEN_W'(1));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FR_IDLE: if (take_hold || load_direct) st_d = FR_TYPE;
            FR_TYPE: if (pkt_ready_i) st_d = FR_TAG;
            FR_TAG:  if (pkt_ready_i) st_d = FR_BODY;
            FR_BODY: if (pkt_ready_i && last_byte) st_d = FR_IDLE;
            default: st_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FR_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data_q   <= '0;
            tx_len_q    <= '0;
            idx_q       <= '0;
            hold_data_q <= '0;
            hold_len_q  <= '0;
            hold_full_q <= 1'b0;
        end else begin
            if (take_hold) begin
                tx_data_q <= hold_data_q;
                tx_len_q  <= hold_len_q;
            end else if (load_direct) begin
                tx_data_q <= rsp_data_i;
                tx_len_q  <= rsp_len_i;
            end
            if (st_q == FR_TAG && pkt_ready_i) idx_q <= '0;
            else if (st_q == FR_BODY && pkt_ready_i && !last_byte) idx_q <= idx_q + LEN_W'(1);
            if (has_data && !load_direct) begin
                hold_data_q <= rsp_data_i;
                hold_len_q  <= rsp_len_i;
                hold_full_q <= 1'b1;
            end else if (take_hold) begin
                hold_full_q <= 1'b0;
            end
        end
    end

    always_comb begin
        pkt_valid_o = (st_q != FR_IDLE);
        pkt_last_o  = last_byte;
        pkt_data_o  = 8'h00;
        unique case (st_q)
            FR_TYPE: pkt_data_o = PKT_TYPE_BUS;
            FR_TAG:  pkt_data_o = PKT_TAG_UNSOL;
            FR_BODY: pkt_data_o = tx_data_q[{idx_q, 3'b000} +: 8];
            default: pkt_data_o = 8'h00;
        endcase
    end

    assign hold_full_o = hold_full_q;

    assert_stall_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)));
    assert_len_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |-> (rsp_len_i <= LEN_W'(MAX_BYTES)));
    assert_hold_not_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_i |-> !hold_full_q);
endmodule

// File: rtl/autopoll_sched.sv
module autopoll_sched
    import autopoll_pkg::*;
#(
    parameter  int RATE_W       = 8,
    parameter  int MASK_W       = 16,
    parameter  int MAX_BYTES    = 8,
    parameter  int DEFAULT_RATE = 20,
    localparam int LEN_W        = $clog2(MAX_BYTES + 1),
    localparam int DATA_W       = MAX_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_sel,
    input  logic [1:0]        cfg_len,
    input  logic [15:0]       cfg_data,
    output logic              cfg_ok,
    output logic              cfg_err,
    input  logic              ms_tick,
    output logic              poll_req,
    output logic [MASK_W-1:0] poll_mask,
    input  logic              poll_rsp_valid,
    input  logic [LEN_W-1:0]  poll_rsp_len,
    input  logic [DATA_W-1:0] poll_rsp_data,
    output logic              pkt_valid,
    output logic [7:0]        pkt_data,
    output logic              pkt_last,
    input  logic              pkt_ready
);
    logic              en, load, stop, hold_full;
    logic [RATE_W-1:0] rate, load_val;

    ap_cfg #(
        .RATE_W(RATE_W), .MASK_W(MASK_W), .DEFAULT_RATE(DEFAULT_RATE), .DEFAULT_MASK('1)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid_i(cfg_valid), .cfg_sel_i(cfg_sel), .cfg_len_i(cfg_len),
        .cfg_data_i(cfg_data), .cfg_ok_o(cfg_ok), .cfg_err_o(cfg_err),
        .en_o(en), .rate_o(rate), .mask_o(poll_mask),
        .load_o(load), .load_val_o(load_val), .stop_o(stop)
    );

    ap_timer #(.RATE_W(RATE_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .en_i(en), .rate_i(rate),
        .load_i(load), .load_val_i(load_val), .stop_i(stop),
        .tick_i(ms_tick), .rsp_seen_i(poll_rsp_valid),
        .hold_full_i(hold_full), .poll_req_o(poll_req)
    );

    ap_framer #(.MAX_BYTES(MAX_BYTES)) i_framer (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid_i(poll_rsp_valid), .rsp_len_i(poll_rsp_len), .rsp_data_i(poll_rsp_data),
        .pkt_ready_i(pkt_ready), .pkt_valid_o(pkt_valid), .pkt_data_o(pkt_data),
        .pkt_last_o(pkt_last), .hold_full_o(hold_full)
    );
endmodule

// File: tb/test_autopoll_sched.sv
module test_autopoll_sched;
    localparam int MAXB  = 8;
    localparam int LEN_W = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [1:0] cfg_len = 2'd0;
    logic [15:0] cfg_data = 16'h0;
    logic cfg_ok, cfg_err;
    logic ms_tick = 1'b0;
    logic poll_req;
    logic [15:0] poll_mask;
    logic poll_rsp_valid = 1'b0;
    logic [LEN_W-1:0] poll_rsp_len = '0;
    logic [MAXB*8-1:0] poll_rsp_data = '0;
    logic pkt_valid, pkt_last;
    logic [7:0] pkt_data;
    logic pkt_ready = 1'b1;

    int checks = 0;
    int failures = 0;
    int polls = 0;
    int bytes_seen = 0;
    bit done = 1'b0;
    logic [8:0] exp_q[$];

    always #4 clk = ~clk;

    autopoll_sched i_autopoll_sched (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
        .cfg_len(cfg_len), .cfg_data(cfg_data), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
        .ms_tick(ms_tick), .poll_req(poll_req), .poll_mask(poll_mask),
        .poll_rsp_valid(poll_rsp_valid), .poll_rsp_len(poll_rsp_len),
        .poll_rsp_data(poll_rsp_data), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_last(pkt_last), .pkt_ready(pkt_ready)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // poll counter and scoreboard monitor, both sampled at the falling edge
    always @(negedge clk) begin
        if (poll_req) polls++;
        if (pkt_valid && pkt_ready) begin
            bytes_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected byte", {pkt_last, pkt_data}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({pkt_last, pkt_data} == e, "R6/R9 packet byte", {pkt_last, pkt_data}, e);
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [1:0] len,
                             input logic [15:0] data, input bit with_tick);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_sel = sel; cfg_len = len; cfg_data = data;
        ms_tick = with_tick;
        @(negedge clk);
        cfg_valid = 1'b0; ms_tick = 1'b0;
        #1;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
            #1;
        end
    endtask

    task automatic respond(input int len, input logic [MAXB*8-1:0] data);
        @(negedge clk);
        poll_rsp_valid = 1'b1; poll_rsp_len = LEN_W'(len); poll_rsp_data = data;
        if (len > 0) begin
            exp_q.push_back({1'b0, 8'h00});
            exp_q.push_back({1'b0, 8'h40});
            for (int i = 0; i < len; i++)
                exp_q.push_back({(i == len - 1), data[i*8 +: 8]});
        end
        @(negedge clk);
        poll_rsp_valid = 1'b0; poll_rsp_len = '0;
        #1;
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", 0, 1);
        if (!done) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(poll_mask == 16'hFFFF, "R1 default mask", poll_mask, 16'hFFFF);
        check(!pkt_valid && !poll_req, "R1 idle outputs", {pkt_valid, poll_req}, 0);

        cfg_write(2'd0, 2'd1, 16'h0001, 1'b0);
        check(cfg_ok && !cfg_err, "R2 enable accepted", {cfg_ok, cfg_err}, 2);
        @(negedge clk); #1;
        check(!cfg_ok, "R12 ok is one cycle", cfg_ok, 0);
        tick_n(19);
        check(polls == 0, "R1 default period not yet", polls, 0);
        tick_n(1);
        check(polls == 1, "R2 poll after period", polls, 1);
        respond(3, 64'h0000_0000_0033_2211);
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R6 packet drained", exp_q.size(), 0);

        tick_n(20);
        check(polls == 2, "R7 re-armed after poll", polls, 2);
        b0 = bytes_seen;
        respond(0, '0);
        repeat (8) @(negedge clk); #1;
        check(bytes_seen == b0, "R7 empty result no packet", bytes_seen, b0);

        cfg_write(2'd1, 2'd1, 16'h0000, 1'b0);
        check(cfg_err, "R4 zero period rejected", cfg_err, 1);
        cfg_write(2'd1, 2'd2, 16'h0005, 1'b0);
        check(cfg_err, "R4 wrong length rejected", cfg_err, 1);
        tick_n(20);
        check(polls == 3, "R4 period unchanged", polls, 3);
        respond(0, '0);

        tick_n(10);
        cfg_write(2'd1, 2'd1, 16'h0003, 1'b0);
        check(cfg_ok, "R4 period accepted", cfg_ok, 1);
        tick_n(2);
        check(polls == 3, "R4 restart not early", polls, 3);
        tick_n(1);
        check(polls == 4, "R4 restart at new period", polls, 4);
        respond(0, '0);
        tick_n(3);
        check(polls == 5, "R7 new period repeats", polls, 5);
        respond(0, '0);

        tick_n(2);
        cfg_write(2'd0, 2'd1, 16'h007F, 1'b0);
        tick_n(1);
        check(polls == 6, "R2 re-enable keeps count", polls, 6);
        respond(0, '0);

        cfg_write(2'd2, 2'd2, 16'h1234, 1'b0);
        check(cfg_ok && poll_mask == 16'h1234, "R5 mask high byte first", poll_mask, 16'h1234);
        cfg_write(2'd2, 2'd1, 16'h00AB, 1'b0);
        check(cfg_err && poll_mask == 16'h1234, "R5 wrong length kept mask", poll_mask, 16'h1234);
        cfg_write(2'd3, 2'd1, 16'h0001, 1'b0);
        check(cfg_err && !cfg_ok, "R12 unused selector rejected", {cfg_ok, cfg_err}, 1);

        tick_n(3);
        check(polls == 7, "R10 poll issued", polls, 7);
        tick_n(3);
        check(polls == 7, "R10 unanswered poll skips", polls, 7);
        respond(0, '0);
        tick_n(3);
        check(polls == 8, "R10 skip re-armed", polls, 8);
        respond(0, '0);

        pkt_ready = 1'b0;
        tick_n(3);
        respond(2, 64'h0000_0000_0000_BBAA);
        tick_n(3);
        check(polls == 10, "R9 poll during stall", polls, 10);
        respond(1, 64'h0000_0000_0000_00CC);
        tick_n(3);
        check(polls == 10, "R10 full hold skips", polls, 10);
        check(pkt_valid && pkt_data == 8'h00, "R6 stalled byte held", pkt_data, 0);
        b0 = bytes_seen;
        @(negedge clk); pkt_ready = 1'b1;
        repeat (20) @(negedge clk); #1;
        check(bytes_seen - b0 == 7 && exp_q.size() == 0, "R9 both packets in order",
              bytes_seen - b0, 7);

        tick_n(2);
        cfg_write(2'd0, 2'd1, 16'h0000, 1'b1);
        check(polls == 10, "R11 disable beats tick", polls, 10);
        tick_n(5);
        check(polls == 10, "R3 no poll when off", polls, 10);

        cfg_write(2'd0, 2'd1, 16'h0001, 1'b0);
        tick_n(2);
        cfg_write(2'd1, 2'd1, 16'h0004, 1'b1);
        tick_n(3);
        check(polls == 10, "R11 restart beats tick", polls, 10);
        tick_n(1);
        check(polls == 11, "R11 new period used", polls, 11);
        respond(0, '0);

        tick_n(1);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick_n(25);
        check(polls == 11, "R8 reset disables", polls, 11);
        check(poll_mask == 16'hFFFF, "R1 mask restored by reset", poll_mask, 16'hFFFF);

        check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule